// File: doc/BRIEF.md
# Ripple Bit-Slice Logic/Arithmetic Unit

This block is a purely combinational logic/arithmetic unit. It is built from identical one-bit slices that are chained by a rippling carry. Two operand words, a carry input and a three-bit operation field go in. A result word one bit wider than the operands comes out, and its top bit is the carry leaving the last slice.

The operation field holds a mode bit and two select bits.

- In **logic mode**, each slice produces one of four functions of its operand bits:
  - pass A
  - invert A
  - XOR
  - XNOR
- In **arithmetic mode**, each slice adds three terms:
  - A or its complement
  - B, or zero when B is gated off
  - the incoming carry

  The carry-out of each slice is the majority of those three terms.

All functions share one XOR path inside the slice. A parameter chooses one of two equivalent carry circuits: an AND-OR majority or a propagate-select multiplexer.

The unit is meant to sit inside a datapath where a registered stage before and after it sets the timing. Because it is a ripple design, its delay grows linearly with the width.

Top module: `ripple_slice_alu`

## Requirements
- R1: The operation field `op_ctrl` is decoded as follows: bit 2 is the mode (0 = logic, 1 = arithmetic), bit 1 is the B-enable select and bit 0 is the A-invert select. With `op_ctrl` = 000, `result[WIDTH-1:0]` equals `opa`.
- R2: With `op_ctrl` = 001, `result[WIDTH-1:0]` equals the bitwise complement of `opa`.
- R3: With `op_ctrl` = 010, `result[WIDTH-1:0]` equals `opa` XOR `opb`.
- R4: With `op_ctrl` = 011, `result[WIDTH-1:0]` equals `opa` XNOR `opb`.
- R5: In logic mode, `carry_in` has no effect on the result, and `result[WIDTH]` is 0.
- R6: In arithmetic mode, `result` (WIDTH+1 bits) equals the sum of three terms: A' + B' + `carry_in`. Here A' is `opa`, or `~opa` when bit 0 is set, and B' is `opb` when bit 1 is set and 0 otherwise.
- R7: When bit 1 of `op_ctrl` is 0, `opb` has no effect on the result, in either mode.
- R8: With `op_ctrl` = 111 and `carry_in` = 1:
  - `result[WIDTH-1:0]` equals `opb` minus `opa`, modulo 2^WIDTH.
  - `result[WIDTH]` is 1 exactly when `opb` >= `opa` (unsigned).
- R9: The carry ripples through every slice. With `opa` all ones, `op_ctrl` = 100 and `carry_in` = 1, the result is 2^WIDTH.
- R10: The width is a parameter (default 8). The two carry circuits selected by `CARRY_FORM` (0 = AND-OR majority, 1 = propagate-select multiplexer) give identical results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into slice 0 (arithmetic mode only) |
| op_ctrl | input | 3 | {mode, B-enable, A-invert} |
| result | output | WIDTH+1 | Function result; top bit is final carry-out |

## Verification
The bench builds two copies of the unit:
- one at the default width of 8 with the AND-OR carry, driven by seeded random operands, operations and carries, plus directed all-ones and zero corners;
- one at width 3 with the multiplexer carry, which is small enough to sweep every combination of operands, carry and operation exhaustively.

Together they cover both carry variants. The narrow copy reaches every ripple pattern, and the wide copy exercises long carry chains such as all-ones plus one.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

   // Per-slice control, decoded once from the operation field
   typedef struct packed {
      logic arith;     // 1: add, 0: logic function
      logic invert_a;  // complement the A bit before use
      logic keep_b;    // let the B bit through (else forced to 0)
   } slice_ctl_t;

   localparam int OP_BITS      = 3;
   localparam int OP_MODE_BIT  = 2;
   localparam int OP_KEEPB_BIT = 1;
   localparam int OP_INVA_BIT  = 0;

   localparam int CARRY_MAJORITY = 0;
   localparam int CARRY_MUXSEL   = 1;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
   import alu_slice_pkg::*;
(
   input  logic [OP_BITS-1:0] op_ctrl,
   output slice_ctl_t         ctl
);

   always_comb begin
      ctl.arith    = op_ctrl[OP_MODE_BIT];
      ctl.invert_a = op_ctrl[OP_INVA_BIT];
      ctl.keep_b   = op_ctrl[OP_KEEPB_BIT];
   end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_slice_pkg::*;
#(
   parameter int CARRY_FORM = CARRY_MAJORITY
) (
   input  logic       a_bit,
   input  logic       b_bit,
   input  logic       c_in,
   input  slice_ctl_t ctl,
   output logic       f_bit,
   output logic       c_out
);

   logic a_x;
   logic b_g;
   logic c_g;
   logic carry_raw;

   // Shared XOR chain: A (maybe inverted), gated B, gated carry
   always_comb begin
      a_x   = a_bit ^ ctl.invert_a;
      b_g   = b_bit & ctl.keep_b;
      c_g   = c_in & ctl.arith;
      f_bit = a_x ^ b_g ^ c_g;
   end

   generate
      if (CARRY_FORM == CARRY_MAJORITY) begin : g_maj
         always_comb carry_raw = (a_x & b_g) | (a_x & c_g) | (b_g & c_g);
      end else begin : g_mux
         logic prop;
         always_comb begin
            prop      = a_x ^ b_g;
            carry_raw = prop ? c_g : a_x;
         end
      end
   endgenerate

   // Logic mode drives the slice carry low
   always_comb c_out = ctl.arith & carry_raw;

endmodule

// File: rtl/ripple_slice_alu.sv
module ripple_slice_alu
   import alu_slice_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int CARRY_FORM = CARRY_MAJORITY
) (
   input  logic [WIDTH-1:0]   opa,
   input  logic [WIDTH-1:0]   opb,
   input  logic               carry_in,
   input  logic [OP_BITS-1:0] op_ctrl,
   output logic [WIDTH:0]     result
);

   localparam int CHAIN = WIDTH + 1;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ripple_slice_alu: WIDTH must be at least 1");
      end
      if (CARRY_FORM != CARRY_MAJORITY && CARRY_FORM != CARRY_MUXSEL) begin : g_bad_form
         $error("ripple_slice_alu: CARRY_FORM must be 0 or 1");
      end
   endgenerate

   slice_ctl_t         ctl;
   logic [CHAIN-1:0]   carry;
   logic [WIDTH-1:0]   fword;

   alu_op_decode u_dec (
      .op_ctrl (op_ctrl),
      .ctl     (ctl)
   );

   always_comb carry[0] = carry_in;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         alu_bit_slice #(.CARRY_FORM(CARRY_FORM)) u_slice (
            .a_bit (opa[i]),
            .b_bit (opb[i]),
            .c_in  (carry[i]),
            .ctl   (ctl),
            .f_bit (fword[i]),
            .c_out (carry[i+1])
         );
      end
   endgenerate

   always_comb result = {carry[WIDTH], fword};

endmodule

// File: rtl/ripple_slice_alu_chk.sv
module ripple_slice_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic             carry_in,
   input logic [2:0]       op_ctrl,
   input logic [WIDTH:0]   result
);

   logic [WIDTH-1:0] a_eff;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   sum_ref;

   always_comb begin
      a_eff   = op_ctrl[0] ? ~opa : opa;
      b_eff   = op_ctrl[1] ? opb : '0;
      sum_ref = {1'b0, a_eff} + {1'b0, b_eff} + (WIDTH+1)'(carry_in);
   end

   always_comb begin
      if (op_ctrl == 3'b000)
         p_pass_r1: assert (result[WIDTH-1:0] == opa) else $error("pass mismatch");
      if (op_ctrl == 3'b001)
         p_invert_r2: assert (result[WIDTH-1:0] == ~opa) else $error("invert mismatch");
      if (op_ctrl == 3'b010)
         p_xor_r3: assert (result[WIDTH-1:0] == (opa ^ opb)) else $error("xor mismatch");
      if (op_ctrl == 3'b011)
         p_xnor_r4: assert (result[WIDTH-1:0] == ~(opa ^ opb)) else $error("xnor mismatch");
      if (!op_ctrl[2])
         p_logic_no_carry_r5: assert (!result[WIDTH]) else $error("carry set in logic mode");
      if (op_ctrl[2])
         p_arith_sum_r6: assert (result == sum_ref) else $error("sum mismatch");
      if (op_ctrl == 3'b111 && carry_in)
         p_subtract_r8: assert (result[WIDTH-1:0] == opb - opa && result[WIDTH] == (opb >= opa))
            else $error("subtract mismatch");
   end

endmodule

bind ripple_slice_alu ripple_slice_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .opa      (opa),
   .opb      (opb),
   .carry_in (carry_in),
   .op_ctrl  (op_ctrl),
   .result   (result)
);

// File: tb/ripple_slice_alu_test.sv
module ripple_slice_alu_test;

   localparam int WA = 8;
   localparam int WB = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [WA-1:0] a8, b8;
   logic          c8;
   logic [2:0]    op8;
   logic [WA:0]   r8;

   logic [WB-1:0] a3, b3;
   logic          c3;
   logic [2:0]    op3;
   logic [WB:0]   r3;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   ripple_slice_alu #(.WIDTH(WA), .CARRY_FORM(0)) uut (
      .opa(a8), .opb(b8), .carry_in(c8), .op_ctrl(op8), .result(r8));

   ripple_slice_alu #(.WIDTH(WB), .CARRY_FORM(1)) uut_w3 (
      .opa(a3), .opb(b3), .carry_in(c3), .op_ctrl(op3), .result(r3));

   function automatic logic [64:0] model(int w, logic [63:0] a, logic [63:0] b,
                                         logic cin, logic [2:0] op);
      logic [63:0] mask, ax, bg;
      mask = (64'd1 << w) - 64'd1;
      ax   = op[0] ? (~a & mask) : (a & mask);
      bg   = op[1] ? (b & mask) : 64'd0;
      if (op[2]) return {1'b0, ax} + {1'b0, bg} + 65'(cin);
      return {1'b0, ax ^ bg};
   endfunction

   function automatic string req_of(logic [2:0] op);
      case (op)
         3'b000:  return "R1";
         3'b001:  return "R2";
         3'b010:  return "R3";
         3'b011:  return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic check(string req, logic [64:0] got, logic [64:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run8(logic [WA-1:0] a, logic [WA-1:0] b, logic cin, logic [2:0] op);
      @(posedge clk);
      a8 = a; b8 = b; c8 = cin; op8 = op;
      @(negedge clk);
   endtask

   task automatic run3(logic [WB-1:0] a, logic [WB-1:0] b, logic cin, logic [2:0] op);
      @(posedge clk);
      a3 = a; b3 = b; c3 = cin; op3 = op;
      @(negedge clk);
   endtask

   initial begin
      logic [WA:0] hold;
      void'($urandom(32'd4242));
      a8 = '0; b8 = '0; c8 = 1'b0; op8 = '0;
      a3 = '0; b3 = '0; c3 = 1'b0; op3 = '0;

      // quiet start: all-zero inputs give zero (R1)
      run8('0, '0, 1'b0, 3'b000);
      check("R1", 65'(r8), 65'd0);

      // directed logic functions on all-ones / zero corners
      run8(8'hFF, 8'h00, 1'b0, 3'b000); check("R1", 65'(r8), 65'h0FF);
      run8(8'hA5, 8'h00, 1'b0, 3'b001); check("R2", 65'(r8), 65'h05A);
      run8(8'hF0, 8'h3C, 1'b0, 3'b010); check("R3", 65'(r8), 65'h0CC);
      run8(8'hF0, 8'h3C, 1'b0, 3'b011); check("R4", 65'(r8), 65'h033);

      // R5: carry_in has no effect in logic mode, top bit stays 0
      for (int k = 0; k < 4; k++) begin
         run8(8'hFF, 8'hFF, 1'b0, 3'(k)); hold = r8;
         run8(8'hFF, 8'hFF, 1'b1, 3'(k));
         check("R5", 65'(r8), 65'(hold));
         check("R5", 65'(r8[WA]), 65'd0);
      end

      // R7: B ignored when bit 1 clear, both modes
      for (int k = 0; k < 8; k++) begin
         if (k[1]) continue;
         run8(8'h5A, 8'h00, 1'b1, 3'(k)); hold = r8;
         run8(8'h5A, 8'hFF, 1'b1, 3'(k));
         check("R7", 65'(r8), 65'(hold));
      end

      // R8: subtraction B - A
      run8(8'd3,   8'd10,  1'b1, 3'b111); check("R8", 65'(r8), 65'h107);
      run8(8'd10,  8'd3,   1'b1, 3'b111); check("R8", 65'(r8), 65'h0F9);
      run8(8'd77,  8'd77,  1'b1, 3'b111); check("R8", 65'(r8), 65'h100);
      run8(8'hFF,  8'h00,  1'b1, 3'b111); check("R8", 65'(r8), 65'h001);

      // R9: full-length carry ripple
      run8(8'hFF, 8'h00, 1'b1, 3'b100); check("R9", 65'(r8), 65'h100);
      run8(8'hFF, 8'h01, 1'b0, 3'b110); check("R9", 65'(r8), 65'h100);
      run8(8'hFF, 8'hFF, 1'b1, 3'b110); check("R6", 65'(r8), 65'h1FF);
      run8(8'h00, 8'h00, 1'b0, 3'b101); check("R6", 65'(r8), 65'h0FF);

      // constrained random on the wide copy
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] op;
         op = 3'($urandom_range(0, 7));
         run8(8'($urandom), 8'($urandom), 1'($urandom), op);
         check(req_of(op), 65'(r8), model(WA, 64'(a8), 64'(b8), c8, op));
      end

      // R10: exhaustive sweep of the narrow mux-carry copy
      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
               for (int c = 0; c < 2; c++) begin
                  run3(3'(a), 3'(b), 1'(c), 3'(op));
                  check("R10", 65'(r3), model(WB, 64'(a), 64'(b), 1'(c), 3'(op)));
               end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule